// File: doc/BRIEF.md
# Rate One-Half Convolutional Encoder

This block turns a serial bit stream into a stream of code symbols carrying two symbols per data bit. Each incoming bit is combined with the six bits that came before it. Two parity taps over that seven-bit window produce the two code symbols. The second symbol is inverted before it leaves the block. The encoder has no framing. It runs for as long as bits arrive, and only reset returns it to a known state.

The block runs on a single clock at twice the bit rate. A one-cycle strobe marks each clock edge where a data bit is taken in. In the cycle after a strobe, the output carries the first symbol of that bit. In the cycle after that, it carries the second symbol. A strobe on every other cycle therefore gives an unbroken symbol stream at twice the input rate. This matches an output that changes on both edges of a bit-rate clock, while the whole design stays on one clock edge.

Top module: `conv_rate_half_enc`

## Requirements
- R1: A clock edge with `rst_n` low clears the six-bit history to zero and drives `code_out` to 0 from the next cycle onward.
- R2: At an edge with `bit_en` high, `din` is sampled. In the following cycle, `code_out` is the even-parity XOR of the window ANDed with 171 octal. Window bit 6 is the bit just sampled, and window bit k is the bit sampled 6-k strobes earlier.
- R3: In the cycle after the first symbol, if no new strobe arrives, `code_out` is the inverse of the XOR of the window ANDed with 133 octal. The window is the same one used for R2.
- R4: The history shifts only at strobe edges. Edges without a strobe leave it unchanged, so the symbols of later bits do not depend on how long the gaps are.
- R5: Once the second symbol has been emitted, `code_out` keeps that value on every edge until the next strobe.
- R6: If a strobe arrives in the cycle straight after another strobe, the new bit's first symbol is emitted, and the unsent second symbol of the earlier bit is dropped.
- R7: With `bit_en` high on every other cycle, `code_out` carries the two symbols of each bit in turn, with no idle cycle between bits.
- R8: After reset and a run of zeros, a single one followed by zeros yields seven pairs, then (0,1). Pair k, for k from 0 to 6, is (bit 6-k of 171 octal, inverse of bit 6-k of 133 octal).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock, twice the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Strobe: sample `din` on this edge |
| din | input | 1 | Serial data bit |
| code_out | output | 1 | Serial code symbol stream |

## Verification
The hardest situations to reach are the irregular strobe patterns. These are a strobe in the cycle directly after another strobe, which drops a pending symbol, and long gaps in which the output must hold while the history stays frozen. The regular every-other-cycle pattern never produces either one. The stimulus therefore mixes a regular stream with random strobe spacings drawn from a seeded generator, including spacings of one cycle and of several cycles. It also adds an impulse run that makes every tap of both generators visible on the output one at a time.

// File: rtl/conv_pkg.sv
// Shared constants and helpers for the rate one-half convolutional encoder.
// Assumes a constraint length of 7 and the generator pair 171/133 octal.
package conv_pkg;
    localparam int unsigned CONV_K      = 7;
    localparam int unsigned CONV_MEM    = CONV_K - 1;
    localparam int unsigned CONV_NSYM   = 2;
    localparam logic [CONV_K-1:0] CONV_POLY_A = 7'o171;
    localparam logic [CONV_K-1:0] CONV_POLY_B = 7'o133;
    localparam logic CONV_INV_A = 1'b0;
    localparam logic CONV_INV_B = 1'b1;

    typedef logic [CONV_K-1:0] conv_window_t;

    // Tapped parity of a window, optionally inverted.
    function automatic logic tap_parity(input conv_window_t w,
                                        input conv_window_t poly,
                                        input logic inv);
        return (^(w & poly)) ^ inv;
    endfunction
endpackage

// File: rtl/conv_history.sv
// Shift register that holds the bits sampled before the current one.
// Index MEM-1 holds the newest previous bit and index 0 the oldest.
// Assumes that bit_en marks the only edges at which the register may shift.
module conv_history #(
    parameter int unsigned MEM = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_en,
    input  logic           din,
    output logic [MEM-1:0] hist
);
    logic [MEM-1:0] hist_q;

    // Shift the new bit in at each strobe; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (bit_en)
            hist_q <= {din, hist_q[MEM-1:1]};
    end

    assign hist = hist_q;

    assert_shift_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> (hist_q[MEM-1] == $past(din)) && (hist_q[MEM-2:0] == $past(hist_q[MEM-1:1])));

    assert_hold_without_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(hist_q));

    assert_cleared_by_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (hist_q == '0));
endmodule

// File: rtl/conv_parity.sv
// One generator tap set: combinational parity over the seven-bit window.
// Assumes that window bit K-1 is the current input bit.
module conv_parity
    import conv_pkg::*;
#(
    parameter int unsigned K = 7,
    parameter logic [K-1:0] POLY = 7'o171,
    parameter logic INVERT = 1'b0
) (
    input  logic [K-1:0] window,
    output logic         sym
);
    // XOR the tapped window bits, then apply the optional inversion.
    always_comb begin
        sym = tap_parity(window, POLY, INVERT);
    end
endmodule

// File: rtl/conv_serializer.sv
// Serializes the two symbols of each bit onto one output at the symbol rate.
// A strobe loads the first symbol and holds back the second, which goes out
// on the next edge unless a fresh strobe takes priority.
// Assumes a single-cycle bit_en pulse for each data bit.
module conv_serializer (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic sym_first,
    input  logic sym_second,
    output logic code_out
);
    logic out_q;
    logic pend_q;
    logic pend_v;

    // Choose between a fresh first symbol, the pending second symbol, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= 1'b0;
            pend_q <= 1'b0;
            pend_v <= 1'b0;
        end else if (bit_en) begin
            out_q  <= sym_first;
            pend_q <= sym_second;
            pend_v <= 1'b1;
        end else if (pend_v) begin
            out_q  <= pend_q;
            pend_v <= 1'b0;
        end
    end

    assign code_out = out_q;

    assert_first_symbol_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> (out_q == $past(sym_first)));

    assert_second_symbol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_en) && !bit_en) |=> (out_q == $past(sym_second, 2)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !pend_v) |=> $stable(out_q));

    assert_pending_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_en) && bit_en) |=> (out_q == $past(sym_first)));
endmodule

// File: rtl/conv_rate_half_enc.sv
// Top level of the rate one-half, constraint length 7 convolutional encoder.
// It runs on a clock at twice the bit rate and samples din on bit_en edges.
// It emits the first-generator symbol and then the inverted second-generator
// symbol. Assumes a synchronous active-low reset.
module conv_rate_half_enc
    import conv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic din,
    output logic code_out
);
    localparam int unsigned K   = CONV_K;
    localparam int unsigned MEM = CONV_MEM;
    localparam int unsigned NS  = CONV_NSYM;

    logic [MEM-1:0] hist;
    logic [K-1:0]   window;
    logic [NS-1:0]  syms;

    conv_history #(.MEM(MEM)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .din    (din),
        .hist   (hist)
    );

    // Form the code window from the current bit and the stored history.
    always_comb begin
        window = {din, hist};
    end

    for (genvar g = 0; g < NS; g++) begin : g_gen
        conv_parity #(
            .K      (K),
            .POLY   ((g == 0) ? CONV_POLY_A : CONV_POLY_B),
            .INVERT ((g == 0) ? CONV_INV_A  : CONV_INV_B)
        ) u_par (
            .window (window),
            .sym    (syms[g])
        );
    end

    conv_serializer u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .sym_first  (syms[0]),
        .sym_second (syms[1]),
        .code_out   (code_out)
    );

    assert_reset_output_R1: assert property (@(posedge clk)
        !rst_n |=> (code_out == 1'b0));

    assert_zero_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !din && (hist == '0)) |=> (code_out == 1'b0));
endmodule

// File: tb/sim_conv_rate_half_enc.sv
module sim_conv_rate_half_enc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic din = 1'b0;
    logic code_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [6:0] GA = 7'o171;
    localparam logic [6:0] GB = 7'o133;

    logic [5:0] m_hist = '0;
    logic m_out = 1'b0;
    logic m_pend = 1'b0;
    logic m_pv = 1'b0;

    conv_rate_half_enc u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .din(din), .code_out(code_out)
    );

    always #4 clk = ~clk;

    function automatic logic sym_a(input logic [6:0] w);
        return ^(w & GA);
    endfunction

    function automatic logic sym_b(input logic [6:0] w);
        return ~(^(w & GB));
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: code_out=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at the next negedge.
    task automatic step(input logic en, input logic d, input logic rn, input string req);
        bit_en = en;
        din    = d;
        rst_n  = rn;
        @(posedge clk);
        if (!rn) begin
            m_hist = '0; m_out = 1'b0; m_pend = 1'b0; m_pv = 1'b0;
        end else if (en) begin
            m_out  = sym_a({d, m_hist});
            m_pend = sym_b({d, m_hist});
            m_pv   = 1'b1;
            m_hist = {d, m_hist[5:1]};
        end else if (m_pv) begin
            m_out = m_pend;
            m_pv  = 1'b0;
        end
        @(negedge clk);
        check(code_out, m_out, req);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: code_out=%0b expected=finish", code_out);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(1'b0, 1'b0, 1'b0, "R1 reset");
        step(1'b0, 1'b0, 1'b0, "R1 reset");

        // R8 impulse: zeros, a single one, then zeros; compare with the taps.
        for (int i = 0; i < 7; i++) begin
            step(1'b1, 1'b0, 1'b1, "R7 zero stream");
            step(1'b0, 1'b0, 1'b1, "R3 zero stream");
        end
        for (int k = 0; k < 8; k++) begin
            step(1'b1, (k == 0), 1'b1, "R8 impulse first");
            check(code_out, (k < 7) ? GA[6-k] : 1'b0, "R8 tap A");
            step(1'b0, 1'b0, 1'b1, "R8 impulse second");
            check(code_out, (k < 7) ? ~GB[6-k] : 1'b1, "R8 tap B");
        end

        // R7 regular stream of random bits.
        for (int i = 0; i < 200; i++) begin
            step(1'b1, 1'($urandom), 1'b1, "R2 regular first");
            step(1'b0, 1'b0, 1'b1, "R3 regular second");
        end

        // R5 and R4: long gaps that must hold the output and freeze the history.
        for (int i = 0; i < 60; i++) begin
            step(1'b1, 1'($urandom), 1'b1, "R2 gap first");
            for (int j = 0; j < 1 + ($urandom % 6); j++)
                step(1'b0, 1'($urandom), 1'b1, "R5 idle hold R4");
        end

        // R6: back-to-back strobes drop the pending second symbol.
        for (int i = 0; i < 40; i++)
            step(1'b1, 1'($urandom), 1'b1, "R6 back-to-back");

        // Mixed random spacing.
        for (int i = 0; i < 2000; i++)
            step(1'(($urandom % 3) == 0), 1'($urandom), 1'b1, "R4 random spacing");

        // R1: reset in mid-stream clears the history; then zeros give (0,1).
        step(1'b1, 1'b1, 1'b1, "R2 before reset");
        step(1'b1, 1'b0, 1'b0, "R1 mid reset");
        check(code_out, 1'b0, "R1 output cleared");
        step(1'b1, 1'b0, 1'b1, "R1 history cleared");
        check(code_out, 1'b0, "R1 zero first symbol");
        step(1'b0, 1'b0, 1'b1, "R3 after reset");
        check(code_out, 1'b1, "R3 inverted zero second symbol");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule